// File: doc/BRIEF.md
# RTC Interrupt Status Register

This block holds the interrupt status of a real-time clock. Three single-cycle event strobes enter it: a periodic tick from the divider chain, an alarm-time match, and the end of an update cycle. Each strobe sets its own sticky flag. Three enable bits come from a control register elsewhere in the clock. The block combines the flags with the enables into one request bit and drives an active-low interrupt line from a register.

A processor reads the state through a small parallel port. Address 0 returns the status byte, and reading it clears every flag. Address 1 returns a second status byte that carries the battery-valid bit. Writes to either address are accepted on the bus and change nothing. A synchronous active-high reset clears the flags and releases the interrupt line. It does not touch the battery-valid bit.

Top module: `rtc_irq_status`

## Requirements
- R1: A strobe on `evt_periodic`, `evt_alarm` or `evt_update` sets its own flag at that clock edge. The flag then stays set until a clearing read of address 0 or a reset.
- R2: A flag sets whether or not its enable input is 1.
- R3: The request bit is 1 exactly when (periodic flag and `en_periodic`) or (alarm flag and `en_alarm`) or (update flag and `en_update`).
- R4: `irq_n` goes to 0 at the clock edge after the first cycle in which the request bit is 1, and it stays 0 while the request bit stays 1.
- R5: A read of address 0 returns in `rdata` the byte {request, periodic flag, alarm flag, update flag, 4'b0000} (bit 7 down to bit 0). The values are those from before the read. The read clears all three flags at the same edge.
- R6: When a strobe arrives in the same cycle as a clearing read, the read returns the old value and the flag for that strobe is set afterwards.
- R7: Reset clears all flags. `irq_n` becomes 1, and `rdata` becomes 0 unless a read is performed in that cycle.
- R8: A read of address 1 returns {`bat_ok`, 7'b0000000}. This read also works while reset is held.
- R9: A write (`wr_en`) to either address with any `wdata` changes no flag and no returned bit.
- R10: `irq_n` returns to 1 at the clock edge after the one at which the flags are cleared.
- R11: A read of address 1 does not clear any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_periodic | input | 1 | Periodic tick strobe |
| evt_alarm | input | 1 | Alarm-match strobe |
| evt_update | input | 1 | Update-ended strobe |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update interrupt enable |
| bat_ok | input | 1 | Battery-good indication |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (ignored) |
| addr | input | 1 | 0 selects the status byte, 1 selects the second status byte |
| wdata | input | 8 | Write data (ignored) |
| rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
Two functions can fall in the same cycle: an event strobe setting a flag, and a read of address 0 clearing all flags. The bench provokes this by pulsing a strobe, either a repeat of a flag that is already set or a fresh one, in the same cycle as a clearing read. It judges the outcome by the value the read returns and by a second read after it. The second read must show the strobed flag still set, and `irq_n` must follow that flag. A behavioural model that runs beside the design checks `rdata` and `irq_n` on every clock. Because the model also covers reset held together with a read, it shows which of two coinciding operations takes priority.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int N_EVT    = 3;
  localparam int EVT_UPD  = 0;
  localparam int EVT_ALM  = 1;
  localparam int EVT_PER  = 2;
  localparam int REQ_BIT  = DATA_W - 1;
  localparam int FLAG_LSB = REQ_BIT - N_EVT;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_VALID  = 1'b1
  } sel_e;
endpackage

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (rst)       flag_q <= 1'b0;
    else if (evt)  flag_q <= 1'b1;
    else if (clr)  flag_q <= 1'b0;
  end

  assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr) |=> flag_q);
  assert_evt_wins_R6: assert property (@(posedge clk) disable iff (rst)
    evt |=> flag_q);
endmodule

// File: rtl/rtc_irq_req.sv
module rtc_irq_req #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  output logic         req,
  output logic         irq_n
);
  logic [N-1:0] gated;

  generate
    for (genvar g = 0; g < N; g++) begin : g_and
      assign gated[g] = flags[g] & enables[g];
    end
  endgenerate

  assign req = |gated;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~req;
  end

  assert_irq_assert_R4: assert property (@(posedge clk) disable iff (rst)
    req |=> !irq_n);
  assert_irq_release_R10: assert property (@(posedge clk) disable iff (rst)
    !req |=> irq_n);
endmodule

// File: rtl/rtc_irq_rdport.sv
module rtc_irq_rdport
  import rtc_irq_pkg::*;
#(
  parameter int W = DATA_W,
  parameter int N = N_EVT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_en,
  input  logic         addr,
  input  logic         req,
  input  logic [N-1:0] flags,
  input  logic         bat_ok,
  output logic [W-1:0] rdata
);
  localparam int PAD_W = W - 1 - N;
  logic [W-1:0] status_byte;
  logic [W-1:0] valid_byte;

  assign status_byte = {req, flags, {PAD_W{1'b0}}};
  assign valid_byte  = {bat_ok, {(W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rd_en)    rdata <= (sel_e'(addr) == SEL_VALID) ? valid_byte : status_byte;
    else if (rst) rdata <= '0;
  end

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rdata[PAD_W-1:0] == '0);
  assert_valid_low_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr) |=> (rdata[W-2:0] == '0));
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  input  logic              en_periodic,
  input  logic              en_alarm,
  input  logic              en_update,
  input  logic              bat_ok,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n
);
  logic [N_EVT-1:0] evt_v;
  logic [N_EVT-1:0] en_v;
  logic [N_EVT-1:0] flags;
  logic             clr;
  logic             req;
  logic             unused_wr;

  assign evt_v[EVT_UPD] = evt_update;
  assign evt_v[EVT_ALM] = evt_alarm;
  assign evt_v[EVT_PER] = evt_periodic;
  assign en_v[EVT_UPD]  = en_update;
  assign en_v[EVT_ALM]  = en_alarm;
  assign en_v[EVT_PER]  = en_periodic;

  assign clr       = rd_en && (sel_e'(addr) == SEL_STATUS);
  assign unused_wr = wr_en ^ (^wdata);

  generate
    for (genvar g = 0; g < N_EVT; g++) begin : g_flag
      rtc_irq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_v[g]),
        .clr    (clr),
        .flag_q (flags[g])
      );
    end
  endgenerate

  rtc_irq_req #(.N(N_EVT)) u_req (
    .clk     (clk),
    .rst     (rst),
    .flags   (flags),
    .enables (en_v),
    .req     (req),
    .irq_n   (irq_n)
  );

  rtc_irq_rdport #(.W(DATA_W), .N(N_EVT)) u_rd (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (rd_en),
    .addr   (addr),
    .req    (req),
    .flags  (flags),
    .bat_ok (bat_ok),
    .rdata  (rdata)
  );

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && !(|evt_v)) |=> (flags == '0));
  assert_rd1_keeps_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr && !(|evt_v)) |=> $stable(flags));
  assert_rst_clears_R7: assert property (@(posedge clk)
    rst |=> (irq_n && flags == '0));
endmodule

// File: tb/test_rtc_irq_status.sv
`timescale 1ns/1ps
module test_rtc_irq_status;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic en_periodic = 0, en_alarm = 0, en_update = 0;
  logic bat_ok = 1, rd_en = 0, wr_en = 0, addr = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic irq_n;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  rtc_irq_status i_rtc_irq_status (
    .clk(clk), .rst(rst),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .en_periodic(en_periodic), .en_alarm(en_alarm), .en_update(en_update),
    .bat_ok(bat_ok), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_pf, m_af, m_uf, m_irqn = 1;
  bit [7:0] m_rd = 8'h00;
  bit model_on = 0;

  always @(posedge clk) begin
    bit req;
    bit clr;
    req = (m_pf && en_periodic) || (m_af && en_alarm) || (m_uf && en_update);
    clr = rd_en && !addr;
    if (rd_en) m_rd = addr ? {bat_ok, 7'd0} : {req, m_pf, m_af, m_uf, 4'd0};
    else if (rst) m_rd = 8'h00;
    m_irqn = rst ? 1'b1 : !req;
    if (rst) begin
      m_pf = 0; m_af = 0; m_uf = 0;
    end else begin
      m_pf = evt_periodic || (m_pf && !clr);
      m_af = evt_alarm    || (m_af && !clr);
      m_uf = evt_update   || (m_uf && !clr);
    end
    #2;
    if (model_on) begin
      check("R5 rdata vs model", rdata, m_rd);
      check("R4 irq_n vs model", irq_n, m_irqn);
    end
  end

  task automatic tick();
    @(posedge clk); #3;
    @(negedge clk);
    evt_periodic = 0; evt_alarm = 0; evt_update = 0;
    rd_en = 0; wr_en = 0;
  endtask

  task automatic rd(input bit a, output logic [7:0] d);
    rd_en = 1; addr = a;
    @(posedge clk); #3; d = rdata;
    @(negedge clk);
    rd_en = 0;
    evt_periodic = 0; evt_alarm = 0; evt_update = 0;
  endtask

  initial begin
    #(200000 * 8);
    n_err++; n_chk++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    @(negedge clk); @(negedge clk);
    model_on = 1;
    rst = 0;
    tick();
    check("R7 reset rdata", rdata, 8'h00);
    check("R7 reset irq_n", irq_n, 1);

    // R2: periodic with enable off
    evt_periodic = 1; tick();
    tick();
    check("R3 no irq when disabled", irq_n, 1);
    rd(0, d); check("R2 flag without enable", d, 8'h40);
    rd(0, d); check("R5 cleared after read", d, 8'h00);

    // R4/R10: alarm enabled
    en_alarm = 1;
    evt_alarm = 1; tick();
    tick();
    check("R4 irq low", irq_n, 0);
    tick();
    check("R1 flag sticky irq", irq_n, 0);
    rd(0, d); check("R3 request bit", d, 8'hA0);
    check("R10 irq still low at clear edge", irq_n, 0);
    tick();
    check("R10 irq released", irq_n, 1);

    // R9: writes ignored
    en_update = 1;
    evt_update = 1; tick();
    wr_en = 1; addr = 0; wdata = 8'hFF; tick();
    wr_en = 1; addr = 1; wdata = 8'h00; tick();
    rd(1, d); check("R9 valid byte after write", d, 8'h80);
    check("R11 irq held after addr1 read", irq_n, 0);
    // R6: coincident event and clearing read
    evt_update = 1;
    rd(0, d); check("R6 read returns old", d, 8'h90);
    rd(0, d); check("R6 flag re-set", d, 8'h90);
    rd(0, d); check("R5 clear", d, 8'h00);

    // R6 fresh event during clearing read
    evt_alarm = 1; tick();
    evt_periodic = 1;
    rd(0, d); check("R6 old value", d, 8'hA0);
    rd(0, d); check("R6 periodic kept", d, 8'h40);

    // R3: flag mismatched with enable
    en_alarm = 0; en_update = 0; en_periodic = 1;
    evt_alarm = 1; tick(); tick();
    check("R3 unmatched enable", irq_n, 1);
    en_alarm = 1; tick(); tick();
    check("R3 enable later", irq_n, 0);

    // R8: valid byte with low battery
    bat_ok = 0;
    rd(1, d); check("R8 low battery", d, 8'h00);
    bat_ok = 1;

    // R7/R8: reset clears flags, valid bit readable in reset
    rst = 1;
    rd(1, d); check("R8 read during reset", d, 8'h80);
    tick();
    check("R7 irq high in reset", irq_n, 1);
    rst = 0;
    rd(0, d); check("R7 flags cleared", d, 8'h00);

    // R1: all three events
    en_alarm = 0; en_periodic = 0;
    evt_periodic = 1; evt_alarm = 1; evt_update = 1; tick();
    repeat (3) tick();
    rd(0, d); check("R1 all flags", d, 8'h70);

    repeat (2) tick();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule